// File: doc/BRIEF.md
# Register-Driven SPI Transaction Engine

This block is an SPI master controlled through four 32-bit registers. Software first loads an opcode/address word and a data word. It then writes a control word that holds a transmit length, a receive length, a chip-select choice and a start bit. The engine asserts one of two active-low chip selects and clocks out the transmit bytes. It then clocks in the receive bytes and writes them back into the same two registers. It releases the chip select and finally drops its busy flag, which software polls.

The transmit bytes and the receive bytes use fixed byte lanes in a different order, and their two lengths are set independently. Serial clocking is SPI mode 0, most significant bit first. The serial clock is the system clock divided by 2, 4, 8 or 16, chosen by a divider code.

Register word index on `reg_addr`: 0 is control/status, 1 is opcode/address (called AO below), 2 is data (called D below), and 3 is the divider.

Top module: `spi_xact_engine`

## Requirements
- R1: After reset the control word reads 0x0002_0000, the divider word reads 0x0003_0000, both `cs_n` bits are high and `sck` is low. Bits [18:17] of the control word always read 1, meaning 24-bit addressing.
- R2: A control write with bit 8 set and legal counts raises busy, which is control bit 16. Busy stays high until the transaction ends. Bit 8 always reads 0, and without a start busy stays low.
- R3: A start request is ignored when the transmit count (bits [3:0]) is 0 or above 8, or when the receive count (bits [7:4]) is above 8. In that case busy does not rise, no chip select falls and no clock pulse appears.
- R4: Transmit byte k (k = 0..7) comes from these lanes: k=0 from AO[7:0], k=1 from AO[31:24], k=2 from AO[23:16], k=3 from AO[15:8], and k=4..7 from D[8(k-4)+7 : 8(k-4)].
- R5: Receive byte j (j = 0..7) goes to these lanes: j=0..3 into D[8j+7:8j], and j=4..7 into AO[8(j-4)+7 : 8(j-4)]. Lanes that receive nothing keep their values.
- R6: Control bit 9 picks the chip select. With 0, only `cs_n[0]` falls; with 1, only `cs_n[1]` falls. It resets to 0, and the two chip selects are never low together.
- R7: A transaction gives exactly 8×(transmit+receive) rising edges of `sck`. Data is sent MSB first; `mosi` changes while `sck` is low and `miso` is sampled on the rising edge. `sck` rests low and is high only while a chip select is low.
- R8: Divider bits [17:16] with code c set the `sck` period to 2^(c+1) system clocks.
- R9: The chip select stays low from the first transmit bit to the last receive bit. It then stays high for at least one `sck` period before busy clears.
- R10: While busy is high, register writes are ignored; this applies to control, AO, D and the divider.
- R11: Control bits [20:19] hold an address-size override that is stored and read back. It resets to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` (combinational) |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 2 | Active-low chip selects |

## Verification
Some rules hold on every cycle, and the assertions check them continuously: the chip selects are mutually exclusive, the serial clock is high only inside a chip-select window, busy rises only for legal counts, busy stays low without a start, register contents are frozen while busy, and a chip-select release comes before busy clears. Other behaviour can only be shown by the bench scenarios, because it depends on the data: the lane order of sent and received bytes, the exact number of clock pulses, the divider period and the ignored illegal starts. The bench sweeps every legal pair of transmit and receive counts, on both chip selects, and every divider code, and compares the results with values it computes arithmetically.

// File: rtl/spi_xe_pkg.sv
package spi_xe_pkg;
    localparam int XE_MAX_BYTES = 8;
    localparam int XE_POS_W     = 7;

    typedef enum logic [1:0] {XE_IDLE, XE_XFER, XE_GAP} xe_state_t;

    typedef struct packed {
        logic [1:0] ovr;
        logic       sel;
        logic [3:0] rxc;
        logic [3:0] txc;
    } xe_ctrl_t;

    function automatic logic counts_ok(input logic [3:0] txc, input logic [3:0] rxc);
        return (txc != 4'd0) && (txc <= 4'(XE_MAX_BYTES)) && (rxc <= 4'(XE_MAX_BYTES));
    endfunction

    function automatic logic [7:0] tx_lane(input logic [2:0] k,
                                           input logic [31:0] ao,
                                           input logic [31:0] dat);
        logic [7:0] b;
        case (k)
            3'd0:    b = ao[7:0];
            3'd1:    b = ao[31:24];
            3'd2:    b = ao[23:16];
            3'd3:    b = ao[15:8];
            default: b = dat[{k[1:0], 3'b000} +: 8];
        endcase
        return b;
    endfunction
endpackage

// File: rtl/spi_xe_divider.sv
module spi_xe_divider #(
    parameter int CODE_W = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              run,
    input  logic [CODE_W-1:0] code,
    output logic              tick
);
    localparam int CNT_W = (1 << CODE_W);

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] half_m1;

    always_comb begin
        half_m1 = (CNT_W'(1) << code) - CNT_W'(1);
        tick    = run && (cnt == half_m1);
    end

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + CNT_W'(1);
    end
endmodule

// File: rtl/spi_xe_core.sv
module spi_xe_core
    import spi_xe_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        start,
    input  logic [3:0]  start_txc,
    input  logic [3:0]  start_rxc,
    input  logic [31:0] ao,
    input  logic [31:0] dat,
    input  logic        tick,
    input  logic        miso,
    output logic        busy,
    output logic        sck,
    output logic        mosi,
    output logic        cs_act,
    output logic        rx_we,
    output logic [2:0]  rx_idx,
    output logic [7:0]  rx_byte
);
    xe_state_t           state;
    logic [XE_POS_W-1:0] bitpos, nb;
    logic [3:0]          txc_q, rxc_q, byte_n, nbyte;
    logic [4:0]          nbytes;
    logic [7:0]          total_m1, lane, lane0;
    logic [6:0]          rsh;
    logic                gapcnt, last, in_rx, next_mosi;

    always_comb begin
        nbytes    = {1'b0, txc_q} + {1'b0, rxc_q};
        total_m1  = {nbytes - 5'd1, 3'b111};
        last      = ({1'b0, bitpos} == total_m1);
        byte_n    = bitpos[6:3];
        in_rx     = (byte_n >= txc_q);
        nb        = bitpos + 7'd1;
        nbyte     = nb[6:3];
        lane      = tx_lane(nbyte[2:0], ao, dat);
        lane0     = tx_lane(3'd0, ao, dat);
        next_mosi = (nbyte < txc_q) ? lane[~nb[2:0]] : 1'b0;
        busy      = (state != XE_IDLE);
        cs_act    = (state == XE_XFER);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= XE_IDLE;
            bitpos <= '0;
            sck    <= 1'b0;
            mosi   <= 1'b0;
            rsh    <= '0;
            gapcnt <= 1'b0;
            txc_q  <= '0;
            rxc_q  <= '0;
            rx_we  <= 1'b0;
            rx_idx <= '0;
            rx_byte <= '0;
        end else begin
            rx_we <= 1'b0;
            case (state)
                XE_IDLE: if (start) begin
                    state  <= XE_XFER;
                    bitpos <= '0;
                    txc_q  <= start_txc;
                    rxc_q  <= start_rxc;
                    mosi   <= lane0[7];
                end
                XE_XFER: if (tick) begin
                    if (!sck) begin
                        sck <= 1'b1;
                        rsh <= {rsh[5:0], miso};
                        if (in_rx && (bitpos[2:0] == 3'd7)) begin
                            rx_we   <= 1'b1;
                            rx_byte <= {rsh, miso};
                            rx_idx  <= 3'(byte_n - txc_q);
                        end
                    end else begin
                        sck <= 1'b0;
                        if (last) begin
                            state  <= XE_GAP;
                            gapcnt <= 1'b0;
                            mosi   <= 1'b0;
                        end else begin
                            bitpos <= nb;
                            mosi   <= next_mosi;
                        end
                    end
                end
                XE_GAP: if (tick) begin
                    if (gapcnt) state <= XE_IDLE;
                    else        gapcnt <= 1'b1;
                end
                default: state <= XE_IDLE;
            endcase
        end
    end

    // R7
    sck_in_window_chk: assert property (@(posedge clk) disable iff (rst)
        sck |-> cs_act);

    // R3
    legal_start_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (txc_q != 4'd0 && txc_q <= 4'd8 && rxc_q <= 4'd8));

    // R9
    release_before_idle_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> !$past(cs_act));
endmodule

// File: rtl/spi_xact_engine.sv
module spi_xact_engine
    import spi_xe_pkg::*;
#(
    parameter int DIV_W = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        reg_wr,
    input  logic [1:0]  reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        sck,
    output logic        mosi,
    input  logic        miso,
    output logic [1:0]  cs_n
);
    localparam logic [DIV_W-1:0] DIV_RESET = '1;

    xe_ctrl_t          ctrl_q;
    logic [31:0]       ao_q, dat_q;
    logic [DIV_W-1:0]  div_q;
    logic              busy, tick, cs_act, rx_we, start_req, wr_ok;
    logic [2:0]        rx_idx;
    logic [7:0]        rx_byte;

    always_comb begin
        wr_ok     = reg_wr && !busy;
        start_req = wr_ok && (reg_addr == 2'd0) && reg_wdata[8]
                    && counts_ok(reg_wdata[3:0], reg_wdata[7:4]);
        cs_n[0]   = ~(cs_act & ~ctrl_q.sel);
        cs_n[1]   = ~(cs_act &  ctrl_q.sel);
        case (reg_addr)
            2'd0:    reg_rdata = {11'd0, ctrl_q.ovr, 2'b01, busy, 6'd0,
                                  ctrl_q.sel, 1'b0, ctrl_q.rxc, ctrl_q.txc};
            2'd1:    reg_rdata = ao_q;
            2'd2:    reg_rdata = dat_q;
            default: reg_rdata = 32'(div_q) << 16;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ao_q   <= '0;
            dat_q  <= '0;
            div_q  <= DIV_RESET;
        end else begin
            if (wr_ok) begin
                case (reg_addr)
                    2'd0: begin
                        ctrl_q.txc <= reg_wdata[3:0];
                        ctrl_q.rxc <= reg_wdata[7:4];
                        ctrl_q.sel <= reg_wdata[9];
                        ctrl_q.ovr <= reg_wdata[20:19];
                    end
                    2'd1:    ao_q  <= reg_wdata;
                    2'd2:    dat_q <= reg_wdata;
                    default: div_q <= reg_wdata[16 +: DIV_W];
                endcase
            end
            if (rx_we) begin
                if (!rx_idx[2]) dat_q[{rx_idx[1:0], 3'b000} +: 8] <= rx_byte;
                else            ao_q[{rx_idx[1:0], 3'b000} +: 8]  <= rx_byte;
            end
        end
    end

    spi_xe_divider #(.CODE_W(DIV_W)) u_div (
        .clk (clk), .rst (rst), .run (busy), .code (div_q), .tick (tick)
    );

    spi_xe_core u_core (
        .clk (clk), .rst (rst), .start (start_req),
        .start_txc (reg_wdata[3:0]), .start_rxc (reg_wdata[7:4]),
        .ao (ao_q), .dat (dat_q), .tick (tick), .miso (miso),
        .busy (busy), .sck (sck), .mosi (mosi), .cs_act (cs_act),
        .rx_we (rx_we), .rx_idx (rx_idx), .rx_byte (rx_byte)
    );

    // R6
    cs_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(~cs_n) <= 1);

    // R2
    idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_req) |=> !busy);

    // R10
    frozen_regs_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> ($stable(ctrl_q) && $stable(div_q)));
endmodule

// File: tb/spi_xact_engine_bench.sv
module spi_xact_engine_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        sck, mosi, miso;
    logic [1:0]  cs_n;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [127:0] cap_bits;
    logic [127:0] resp_bits;
    int           sc = 0;
    int           cs_viol = 0;
    logic [1:0]   exp_cs = 2'b10;
    int           hi_cnt = 0;
    longint       t_rise0 = 0, t_rise1 = 0;

    always #2 clk = ~clk;

    spi_xact_engine u_spi_xact_engine (
        .clk (clk), .rst (rst), .reg_wr (reg_wr), .reg_addr (reg_addr),
        .reg_wdata (reg_wdata), .reg_rdata (reg_rdata), .sck (sck),
        .mosi (mosi), .miso (miso), .cs_n (cs_n)
    );

    assign miso = (sc < 128) ? resp_bits[sc] : 1'b0;

    always @(posedge sck) begin
        if (sc < 128) cap_bits[sc] <= mosi;
        if (cs_n !== exp_cs) cs_viol <= cs_viol + 1;
        if (sc == 0) t_rise0 <= $time;
        if (sc == 1) t_rise1 <= $time;
        sc <= sc + 1;
    end

    always @(posedge clk) begin
        if (&cs_n) hi_cnt <= hi_cnt + 1;
        else       hi_cnt <= 0;
    end

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] v;
        for (int i = 0; i < 5000; i++) begin
            rd(2'd0, v);
            if (!v[16]) break;
        end
    endtask

    function automatic logic [7:0] exp_tx(input int k, input logic [31:0] a, input logic [31:0] d);
        if (k == 0) return a[7:0];
        if (k < 4)  return 8'((a >> (8 * (4 - k))) & 32'hFF);
        return 8'((d >> (8 * (k - 4))) & 32'hFF);
    endfunction

    function automatic logic [7:0] rv(input int j, input int tx, input int rx);
        return 8'((8'hA5 ^ (j * 37) ^ (tx << 4) ^ rx) & 8'hFF);
    endfunction

    task automatic xact(input int tx, input int rx, input bit sel, input int code,
                        input logic [31:0] a, input logic [31:0] d);
        logic [31:0] v, ea, ed;
        int half;
        bit tx_ok;
        half = 1 << code;
        wr(2'd1, a);
        wr(2'd2, d);
        resp_bits = '0;
        for (int j = 0; j < rx; j++)
            for (int b = 0; b < 8; b++)
                resp_bits[8 * (tx + j) + b] = rv(j, tx, rx)[7 - b];
        sc = 0; cs_viol = 0;
        exp_cs = sel ? 2'b01 : 2'b10;
        wr(2'd0, 32'h100 | (32'(sel) << 9) | (32'(rx) << 4) | 32'(tx));
        rd(2'd0, v);
        // R2: busy raised, start bit reads 0
        chk(v[16] == 1'b1 && v[8] == 1'b0, "R2 busy/start", longint'(v), 32'h10000);
        wait_idle();
        // R9: chip select high at least one sck period before busy clears
        chk(hi_cnt >= 2 * half, "R9 release gap", hi_cnt, 2 * half);
        chk(cs_n == 2'b11 && sck == 1'b0, "R9 idle lines", {cs_n, sck}, 3'b110);
        // R7: clock count
        chk(sc == 8 * (tx + rx), "R7 sck count", sc, 8 * (tx + rx));
        // R6: correct chip select only
        chk(cs_viol == 0, "R6 chip select", cs_viol, 0);
        // R8: sck period
        chk(t_rise1 - t_rise0 == 8 * half, "R8 sck period", t_rise1 - t_rise0, 8 * half);
        // R4: transmit lanes
        tx_ok = 1;
        for (int k = 0; k < tx; k++)
            for (int b = 0; b < 8; b++)
                if (cap_bits[8 * k + b] !== exp_tx(k, a, d)[7 - b]) tx_ok = 0;
        chk(tx_ok, "R4 tx lanes", tx, tx);
        // R5: receive lanes
        ea = a; ed = d;
        for (int j = 0; j < rx; j++)
            if (j < 4) ed[8 * j +: 8] = rv(j, tx, rx);
            else       ea[8 * (j - 4) +: 8] = rv(j, tx, rx);
        rd(2'd2, v);
        chk(v == ed, "R5 rx data lanes", v, ed);
        rd(2'd1, v);
        chk(v == ea, "R5 rx ao lanes", v, ea);
    endtask

    initial begin
        #(4 * 190000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1: reset state
        rd(2'd0, v);
        chk(v == 32'h0002_0000, "R1 ctrl reset", v, 32'h0002_0000);
        rd(2'd3, v);
        chk(v == 32'h0003_0000, "R1 divider reset", v, 32'h0003_0000);
        chk(cs_n == 2'b11 && sck == 1'b0, "R1 idle lines", {cs_n, sck}, 3'b110);

        // R11: override field storage
        wr(2'd0, 32'h0010_0000);
        rd(2'd0, v);
        chk(v[20:19] == 2'd2 && v[18:17] == 2'd1 && v[16] == 1'b0, "R11 override", v, 32'h0012_0000);
        wr(2'd0, 32'h0008_0000);
        rd(2'd0, v);
        chk(v[20:19] == 2'd1, "R11 override 16", v[20:19], 1);

        // R3: illegal counts
        sc = 0;
        wr(2'd0, 32'h100 | 32'h00);
        rd(2'd0, v);
        chk(v[16] == 1'b0, "R3 tx zero", v[16], 0);
        wr(2'd0, 32'h100 | 32'h19);
        rd(2'd0, v);
        chk(v[16] == 1'b0, "R3 tx nine", v[16], 0);
        wr(2'd0, 32'h100 | 32'h91);
        rd(2'd0, v);
        chk(v[16] == 1'b0, "R3 rx nine", v[16], 0);
        repeat (40) @(negedge clk);
        chk(sc == 0 && cs_n == 2'b11, "R3 no activity", sc, 0);

        // R2: no start bit -> no transaction
        wr(2'd0, 32'h0000_0011);
        rd(2'd0, v);
        chk(v[16] == 1'b0 && v[7:0] == 8'h11, "R2 write without start", v, 32'h0002_0011);

        // Full sweep at the fastest divider
        wr(2'd3, 32'h0000_0000);
        for (int tx = 1; tx <= 8; tx++)
            for (int rx = 0; rx <= 8; rx++)
                xact(tx, rx, 1'((tx + rx) & 1), 0,
                     32'h1234_5600 ^ 32'(tx * 32'h0101_0101) ^ 32'(rx << 8),
                     32'hDEAD_BEEF ^ 32'(rx * 32'h0011_0011));

        // R8: every divider code
        for (int c = 0; c < 4; c++) begin
            wr(2'd3, 32'(c) << 16);
            xact(2, 1, 1'(c & 1), c, 32'hA1B2_C3D4, 32'h0F1E_2D3C);
        end

        // R10: writes ignored while busy (divider at slowest)
        wr(2'd3, 32'h0003_0000);
        wr(2'd1, 32'h0000_0006);
        wr(2'd2, 32'h5555_AAAA);
        sc = 0; exp_cs = 2'b10;
        wr(2'd0, 32'h0000_0101);
        wr(2'd1, 32'hFFFF_FFFF);
        wr(2'd2, 32'h0000_0000);
        wr(2'd3, 32'h0000_0000);
        wr(2'd0, 32'h0018_0233);
        rd(2'd0, v);
        chk(v[16] == 1'b1, "R10 still busy", v[16], 1);
        wait_idle();
        rd(2'd1, v);
        chk(v == 32'h0000_0006, "R10 ao frozen", v, 32'h6);
        rd(2'd2, v);
        chk(v == 32'h5555_AAAA, "R10 data frozen", v, 32'h5555_AAAA);
        rd(2'd3, v);
        chk(v == 32'h0003_0000, "R10 divider frozen", v, 32'h0003_0000);
        rd(2'd0, v);
        chk(v == 32'h0002_0001, "R10 ctrl frozen", v, 32'h0002_0001);
        chk(sc == 8, "R10 single byte", sc, 8);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule